// File: doc/BRIEF.md
# Memory Address-Pattern Self-Test Engine

This engine runs once memory initialization has finished and exercises every word of an attached memory through a word-wide request/acknowledge port. A start pulse latches the memory geometry and the base address. The engine then fills each word with its own word index, in ascending order. Only after every word has been written does it read all of the words back in the same order and compare each value with the index it should hold.

The memory size is derived from the row, column and bank address widths and from the data bus width. When the test passes, the engine reports that size. At the first mismatch it stops without issuing another request. It then reports the failing byte address, the value read and the value expected, and it gives a size of zero. A one-cycle done strobe marks the end of a run. The result outputs hold their values until the next accepted start.

Top module: `memtest_engine`

## Requirements
- R1: With `half_bus` low (32-bit bus), the size reported on success is 2^(row_bits+col_bits+bank_bits+2) bytes.
- R2: With `half_bus` high (16-bit bus), the size is 2^(row_bits+col_bits+bank_bits+1) bytes. In both bus modes the number of words tested is that size divided by 4.
- R3: The write pass writes word index i to byte address base_addr+4*i, with `mem_we` high and `mem_wdata` equal to i. Indices ascend from 0 and cover every word once.
- R4: No read is issued before the last write has been acknowledged. Reads then run at ascending byte addresses base_addr+4*i, starting at i=0, and a write never follows a read within one run.
- R5: The first read whose data differs from its index ends the run. No further memory request follows that read.
- R6: On a failure, `pass` is 0 and `mem_size` is 0. `fail_addr` holds base_addr+4*i, `fail_rdata` holds the value read and `fail_expect` holds i.
- R7: On success, `pass` is 1, `mem_size` holds the computed size, and all three failure fields are 0.
- R8: `done` is high for exactly one cycle, in the cycle after the final acknowledge. `busy` is high from the cycle after an accepted start until that final acknowledge. The outputs `pass`, `mem_size` and the failure fields keep their values until the next accepted start, which clears them to 0.
- R9: Only one request is outstanding at a time. While `mem_req` is high and `mem_ack` is low, the address, write enable and write data do not change.
- R10: A start pulse that arrives while `busy` is high is ignored, and the running test continues unchanged.
- R11: After reset, `busy`, `mem_req`, `done` and `pass` are 0 and `mem_size` is 0. `mem_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Start pulse, accepted only while idle |
| base_addr | input | ADDR_W | Byte address of word 0 |
| row_bits | input | GEO_W | Row address width |
| col_bits | input | GEO_W | Column address width |
| bank_bits | input | GEO_W | Bank address width |
| half_bus | input | 1 | 1 = 16-bit data bus, 0 = 32-bit data bus |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data (the word index) |
| mem_ack | input | 1 | Acknowledge; read data is valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Whole memory matched |
| mem_size | output | ADDR_W | Size in bytes on success, 0 on failure |
| fail_addr | output | ADDR_W | Byte address of the first mismatch |
| fail_rdata | output | DATA_W | Value read at the first mismatch |
| fail_expect | output | DATA_W | Value expected at the first mismatch |

## Verification
The assertions assume that `mem_ack` is raised only in response to a pending request, and for a single cycle per transfer. They also assume that the geometry keeps the size exponent below ADDR_W and gives at least one word. The bench memory model meets these conditions: it waits a random latency of 0 to 3 cycles, acknowledges once, and drops `mem_ack` in the following cycle. Random geometries are drawn with row and column widths of at least 1, so the word count stays between 2 and 512 and fits the model array. Directed runs place a fault at the first and last words, alias the upper half of the memory onto the lower half, and pulse start in the middle of a run.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } mt_state_e;
endpackage

// File: rtl/memtest_sizer.sv
module memtest_sizer #(
  parameter int ADDR_W = 32,
  parameter int GEO_W  = 5
) (
  input  logic [GEO_W-1:0]    row_bits,
  input  logic [GEO_W-1:0]    col_bits,
  input  logic [GEO_W-1:0]    bank_bits,
  input  logic                half_bus,
  output logic [ADDR_W-1:0]   size_bytes,
  output logic [ADDR_W-3:0]   last_idx
);
  localparam int EXP_W = GEO_W + 2;
  localparam int IDX_W = ADDR_W - 2;

  logic [EXP_W-1:0] expo;

  always_comb begin
    expo = EXP_W'(row_bits) + EXP_W'(col_bits) + EXP_W'(bank_bits)
         + (half_bus ? EXP_W'(1) : EXP_W'(2));
    size_bytes = ADDR_W'(1) << expo;
    last_idx   = IDX_W'((size_bytes >> 2) - ADDR_W'(1));
  end
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] size_in,
  input  logic [ADDR_W-3:0] last_in,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              start_acc,
  output logic              finish,
  output logic              fail_hit,
  output logic [ADDR_W-1:0] size_q
);
  localparam int IDX_W = ADDR_W - 2;

  mt_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_q;
  logic [ADDR_W-1:0] base_q;
  logic              at_last, mismatch, rd_ack;

  always_comb begin
    busy      = (state_q != ST_IDLE);
    start_acc = start && !busy;
    at_last   = (idx_q == last_q);
    mem_req   = busy;
    mem_we    = (state_q == ST_WRITE);
    mem_addr  = base_q + {idx_q, 2'b00};
    mem_wdata = DATA_W'(idx_q);
    mismatch  = (mem_rdata != mem_wdata);
    rd_ack    = (state_q == ST_READ) && mem_ack;
    fail_hit  = rd_ack && mismatch;
    finish    = rd_ack && (mismatch || at_last);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (start_acc) begin
        state_d = ST_WRITE;
        idx_d   = '0;
      end
      ST_WRITE: if (mem_ack) begin
        if (at_last) begin
          state_d = ST_READ;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_READ: if (mem_ack) begin
        if (mismatch || at_last) state_d = ST_IDLE;
        else                     idx_d   = idx_q + IDX_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
      size_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (start_acc) begin
        last_q <= last_in;
        base_q <= base_addr;
        size_q <= size_in;
      end
    end
  end
endmodule

// File: rtl/memtest_report.sv
module memtest_report #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              finish,
  input  logic              fail_hit,
  input  logic [ADDR_W-1:0] size_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic [DATA_W-1:0] expect_in,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] mem_size,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_rdata,
  output logic [DATA_W-1:0] fail_expect
);
  logic load_en;
  assign load_en = start_acc || finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      pass        <= 1'b0;
      mem_size    <= '0;
      fail_addr   <= '0;
      fail_rdata  <= '0;
      fail_expect <= '0;
    end else begin
      done <= finish;
      if (load_en) begin
        pass        <= finish && !fail_hit;
        mem_size    <= (finish && !fail_hit) ? size_in : '0;
        fail_addr   <= fail_hit ? addr_in   : '0;
        fail_rdata  <= fail_hit ? rdata_in  : '0;
        fail_expect <= fail_hit ? expect_in : '0;
      end
    end
  end
endmodule

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int GEO_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [GEO_W-1:0]  row_bits,
  input  logic [GEO_W-1:0]  col_bits,
  input  logic [GEO_W-1:0]  bank_bits,
  input  logic              half_bus,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] mem_size,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_rdata,
  output logic [DATA_W-1:0] fail_expect
);
  localparam int IDX_W = ADDR_W - 2;

  logic              rst_meta, rst_sync_n;
  logic [ADDR_W-1:0] size_calc, size_held;
  logic [IDX_W-1:0]  last_calc;
  logic              start_acc, finish, fail_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  memtest_sizer #(.ADDR_W(ADDR_W), .GEO_W(GEO_W)) u_sizer (
    .row_bits  (row_bits),
    .col_bits  (col_bits),
    .bank_bits (bank_bits),
    .half_bus  (half_bus),
    .size_bytes(size_calc),
    .last_idx  (last_calc)
  );

  memtest_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .base_addr(base_addr),
    .size_in  (size_calc),
    .last_in  (last_calc),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .start_acc(start_acc),
    .finish   (finish),
    .fail_hit (fail_hit),
    .size_q   (size_held)
  );

  memtest_report #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_report (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_acc  (start_acc),
    .finish     (finish),
    .fail_hit   (fail_hit),
    .size_in    (size_held),
    .addr_in    (mem_addr),
    .rdata_in   (mem_rdata),
    .expect_in  (mem_wdata),
    .done       (done),
    .pass       (pass),
    .mem_size   (mem_size),
    .fail_addr  (fail_addr),
    .fail_rdata (fail_rdata),
    .fail_expect(fail_expect)
  );
endmodule

// File: rtl/memtest_checker.sv
module memtest_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] mem_size,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [DATA_W-1:0] fail_rdata,
  input logic [DATA_W-1:0] fail_expect
);
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$past(start) |-> $stable(pass) && $stable(mem_size) && $stable(fail_addr)
                               && $stable(fail_rdata) && $stable(fail_expect));

  a_r6_fail_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pass |-> mem_size == '0);

  a_r7_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> mem_size != '0 && fail_addr == '0 && fail_rdata == '0 && fail_expect == '0);

  a_r11_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r4_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(mem_req && !mem_we) |-> !mem_we);

  a_r5_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind memtest_engine memtest_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_size   (mem_size),
  .fail_addr  (fail_addr),
  .fail_rdata (fail_rdata),
  .fail_expect(fail_expect)
);

// File: tb/memtest_engine_tb.sv
module memtest_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [4:0]  row_bits = '0, col_bits = '0, bank_bits = '0;
  logic        half_bus = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, pass;
  logic [31:0] mem_size, fail_addr, fail_rdata, fail_expect;

  always #10 clk = ~clk;

  memtest_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .row_bits(row_bits), .col_bits(col_bits), .bank_bits(bank_bits), .half_bus(half_bus),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass),
    .mem_size(mem_size), .fail_addr(fail_addr), .fail_rdata(fail_rdata), .fail_expect(fail_expect)
  );

  int n_chk = 0, n_bad = 0;

  // memory model
  logic [31:0] mem [0:1023];
  int unsigned alias_mask = 1023;
  int          corrupt_idx = -1;
  logic [31:0] flip = 32'h1;
  int unsigned words_now = 0;
  int unsigned wr_cnt = 0, rd_cnt = 0, ord_err = 0;
  int unsigned lat = 0;

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat != 0) lat = lat - 1;
      else begin
        int unsigned off;
        off = (mem_addr - base_addr) >> 2;
        if (mem_we) begin
          if (mem_addr != base_addr + 4 * wr_cnt || mem_wdata != wr_cnt || rd_cnt != 0) ord_err++;
          mem[off & alias_mask & 1023] = mem_wdata;
          wr_cnt++;
        end else begin
          if (wr_cnt != words_now || mem_addr != base_addr + 4 * rd_cnt) ord_err++;
          mem_rdata <= mem[off & alias_mask & 1023] ^ ((int'(off) == corrupt_idx) ? flip : 32'h0);
          rd_cnt++;
        end
        mem_ack <= 1'b1;
        lat = $urandom % 4;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_size(input int r, input int c, input int b, input bit h);
    return 32'd1 << (r + c + b + (h ? 1 : 2));
  endfunction

  task automatic run_test(input int r, input int c, input int b, input bit h, input logic [31:0] base,
                          input int corrupt, input bit do_alias, input bit mid_start);
    logic [31:0] sz, e_addr, e_rd, e_ex, s_size, s_faddr;
    int unsigned words, e_reads;
    bit e_pass, timeout;
    int cyc;
    sz = exp_size(r, c, b, h);
    words = sz >> 2;
    row_bits = 5'(r); col_bits = 5'(c); bank_bits = 5'(b); half_bus = h; base_addr = base;
    corrupt_idx = corrupt;
    flip = 32'h1 << ($urandom % 32);
    alias_mask = do_alias ? (words / 2 - 1) : 1023;
    words_now = words; wr_cnt = 0; rd_cnt = 0; ord_err = 0;
    if (do_alias) begin
      e_pass = 0; e_addr = base; e_rd = words / 2; e_ex = 0; e_reads = 1;
    end else if (corrupt >= 0 && corrupt < int'(words)) begin
      e_pass = 0; e_addr = base + 4 * corrupt; e_rd = corrupt ^ flip; e_ex = corrupt; e_reads = corrupt + 1;
    end else begin
      e_pass = 1; e_addr = 0; e_rd = 0; e_ex = 0; e_reads = words;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", 32'(busy), 1);
    chk(mem_size == 0 && pass == 1'b0, "R8 results cleared by start", mem_size, 0);
    cyc = 0; timeout = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (mid_start && cyc == 10) start = 1'b1;
      if (cyc == 11) start = 1'b0;
      if (cyc > 20000) begin timeout = 1; break; end
    end
    chk(!timeout, "watchdog", cyc, 20000);
    chk(pass == e_pass, h ? "R2 pass flag" : "R7 pass flag", 32'(pass), 32'(e_pass));
    chk(mem_size == (e_pass ? sz : 0), h ? "R2 size" : (e_pass ? "R1 size" : "R6 size zero"), mem_size, e_pass ? sz : 0);
    chk(fail_addr == e_addr, "R6 fail_addr", fail_addr, e_addr);
    chk(fail_rdata == e_rd, "R6 fail_rdata", fail_rdata, e_rd);
    chk(fail_expect == e_ex, "R6 fail_expect", fail_expect, e_ex);
    chk(wr_cnt == words, mid_start ? "R10 write count" : "R3 write count", wr_cnt, words);
    chk(ord_err == 0, "R4 address order", ord_err, 0);
    chk(rd_cnt == e_reads, "R5 read count", rd_cnt, e_reads);
    chk(busy == 1'b0, "R8 busy low at done", 32'(busy), 0);
    s_size = mem_size; s_faddr = fail_addr;
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 32'(done), 0);
    repeat (4) begin
      @(negedge clk);
      chk(!mem_req && rd_cnt == e_reads, "R5 no request after end", rd_cnt, e_reads);
    end
    chk(mem_size == s_size && fail_addr == s_faddr, "R8 results held", fail_addr, s_faddr);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 0 && mem_req == 0 && done == 0, "R11 reset idle", {busy, mem_req, done}, 0);
    chk(pass == 0 && mem_size == 0, "R11 reset results", mem_size, 0);

    run_test(2, 3, 1, 0, 32'h1000_0000, -1, 0, 0);   // R1 pass
    run_test(2, 3, 1, 1, 32'h1000_0000, -1, 0, 0);   // R2 half bus
    run_test(1, 1, 0, 1, 32'h0000_0040, -1, 0, 0);   // R2 smallest: 2 words
    run_test(2, 2, 1, 0, 32'h2000_0000, 31, 0, 0);   // R6 last word
    run_test(2, 2, 1, 0, 32'h2000_0000, 0, 0, 0);    // R6 first word
    run_test(2, 2, 2, 0, 32'h3000_0100, -1, 1, 0);   // R5 aliasing
    run_test(3, 3, 1, 0, 32'h0800_0000, -1, 0, 1);   // R10 start while busy

    for (int k = 0; k < 16; k++) begin
      int r, c, b, w, cor;
      bit h;
      r = 1 + $urandom % 3; c = 1 + $urandom % 4; b = $urandom % 3; h = 1'($urandom % 2);
      w = exp_size(r, c, b, h) >> 2;
      cor = ($urandom % 2) ? int'($urandom % w) : -1;
      run_test(r, c, b, h, {$urandom % 32'h4000, 16'h0} & 32'hFFFF_FFFC, cor, 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule